// File: doc/BRIEF.md
# Multi-mode 8-bit timer/event counter

This block is an 8-bit up-counter that counts from a value held in a preload register. When it wraps past all-ones it reloads that value, sets an interrupt request flag and gives a one-cycle wake-up strobe. A two-bit mode field selects what drives the counter. Timer mode counts an internal tick. Event mode counts rising edges on an external pin. Pulse-width mode counts the internal tick only while the external pin is high. The internal tick is either every system clock or each rising edge of a slow real-time clock input, chosen by a source bit.

Software reaches the block through a small register port with four addresses. The external pin and the slow clock input are both brought into the system clock domain through two-stage synchronisers. In pulse-width mode the block measures one pulse and then clears its own run bit. In the other modes the counter keeps running until software stops it.

Top module: `tec8_unit`

## Requirements
- R1: After the synchronous reset, every register reads 0, and `irq_o` and `wake_o` are 0.
- R2: Address 1 is the control register. Bit 0 is run, bit 1 is the tick source (0 = system clock, 1 = slow clock) and bits 3:2 are the mode. With mode 10 (timer) and source 0, the counter advances by one on every system clock while run is 1.
- R3: In timer mode with source 1, the counter advances once per rising edge of `slow_clk_i` and does not advance on system clocks alone.
- R4: In mode 01 (event), the counter advances once per rising edge of `ext_i`.
- R5: In mode 11 (pulse width), the counter advances on the internal tick while `ext_i` is high. The first falling edge of `ext_i` after counting has begun clears the run bit, and later pulses leave the count unchanged. In the other modes, only a control write clears run.
- R6: Mode 00 never changes the counter, even with run set.
- R7: An advance from 8'hFF loads the counter with the value the preload register held before that clock edge.
- R8: A write to address 0 always updates the preload register (read back at address 3). It also loads the counter directly only when run is 0. Address 0 reads the live counter.
- R9: An overflow sets the flag at address 2, bit 0. `irq_o` is the flag ANDed with the enable at address 2, bit 1. Writing 0 to bit 0 clears the flag, writing 1 leaves it unchanged, and a control write never touches it.
- R10: When an overflow and a flag-clearing write fall in the same cycle, the flag ends up set.
- R11: `wake_o` pulses for one cycle after each overflow, whatever the value of the enable bit.
- R12: `reg_rdata` is registered. It shows the addressed register as it stood at the clock edge that follows the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Slow real-time clock, sampled as data |
| ext_i | input | 1 | External event / gate input |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | One-cycle wake-up strobe |

## Verification
An overflow and a software write to the flag register can land on the same clock edge. In that case the hardware set must beat the software clear. The bench provokes this by starting timer mode from 8'hFE with back-to-back writes, so that the flag-clearing write lands on the exact edge where the counter wraps. It then reads the flag back and expects 1. The same bench also runs a write to address 0 during counting against a later overflow, to confirm that the reload takes the stored preload value and not a direct load.

// File: rtl/tec8_pkg.sv
package tec8_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } tmode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_PRE   = 2'd3;

  localparam int B_RUN  = 0;
  localparam int B_SRC  = 1;
  localparam int B_MLO  = 2;
  localparam int B_MHI  = 3;
  localparam int B_FLAG = 0;
  localparam int B_IE   = 1;
endpackage

// File: rtl/tec8_sync.sv
module tec8_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign prev  = sh[STAGES];
endmodule

// File: rtl/tec8_count.sv
module tec8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] pre,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;

  assign ovf = step && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= ovf ? pre : cnt + 1'b1;
  end
endmodule

// File: rtl/tec8_ctl.sv
module tec8_ctl
  import tec8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_wdata,
  input  logic       flag_wr,
  input  logic [1:0] flag_wdata,
  input  logic       ovf,
  input  logic       step,
  input  logic       ext_fall,
  output logic       run,
  output logic       src,
  output logic [1:0] mode,
  output logic       flag,
  output logic       ie,
  output logic       irq_o,
  output logic       wake_o
);
  logic pw_seen;
  logic flag_n, ie_n;
  logic pw_end;

  assign pw_end = run && (mode == MODE_PW) && pw_seen && ext_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      src  <= 1'b0;
      mode <= MODE_OFF;
    end else if (ctrl_wr) begin
      run  <= ctrl_wdata[B_RUN];
      src  <= ctrl_wdata[B_SRC];
      mode <= ctrl_wdata[B_MHI:B_MLO];
    end else if (pw_end) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl_wr || !run) pw_seen <= 1'b0;
    else if (mode == MODE_PW && step) pw_seen <= 1'b1;
  end

  always_comb begin
    flag_n = flag_wr ? (flag & flag_wdata[B_FLAG]) : flag;
    flag_n = flag_n | ovf;
    ie_n   = flag_wr ? flag_wdata[B_IE] : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      ie     <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      flag   <= flag_n;
      ie     <= ie_n;
      irq_o  <= flag_n & ie_n;
      wake_o <= ovf;
    end
  end
endmodule

// File: rtl/tec8_unit.sv
module tec8_unit
  import tec8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int N_IN = 2;
  localparam int I_EXT = 0;
  localparam int I_SLOW = 1;

  logic [N_IN-1:0] raw, lvl, prv;
  assign raw[I_EXT]  = ext_i;
  assign raw[I_SLOW] = slow_clk_i;

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    tec8_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(raw[g]), .level(lvl[g]), .prev(prv[g])
    );
  end

  logic ext_rise, ext_fall, slow_rise;
  assign ext_rise  = lvl[I_EXT]  & ~prv[I_EXT];
  assign ext_fall  = ~lvl[I_EXT] &  prv[I_EXT];
  assign slow_rise = lvl[I_SLOW] & ~prv[I_SLOW];

  logic             run_q, src_q, flag_q, ie_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] pre_q, cnt_q;
  logic             ovf, step, load, tick;
  tmode_e           md;

  assign md   = tmode_e'(mode_q);
  assign tick = src_q ? slow_rise : 1'b1;

  always_comb begin
    unique case (md)
      MODE_EVT: step = run_q & ext_rise;
      MODE_TMR: step = run_q & tick;
      MODE_PW:  step = run_q & tick & lvl[I_EXT];
      default:  step = 1'b0;
    endcase
  end

  logic wr_cnt, wr_ctrl, wr_flag;
  assign wr_cnt  = reg_wr && (reg_addr == A_COUNT);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign load    = wr_cnt && !run_q;

  always_ff @(posedge clk) begin
    if (rst)         pre_q <= '0;
    else if (wr_cnt) pre_q <= reg_wdata;
  end

  tec8_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .step(step), .load(load), .load_val(reg_wdata),
    .pre(pre_q), .cnt(cnt_q), .ovf(ovf)
  );

  tec8_ctl u_ctl (
    .clk(clk), .rst(rst),
    .ctrl_wr(wr_ctrl), .ctrl_wdata(reg_wdata[B_MHI:0]),
    .flag_wr(wr_flag), .flag_wdata(reg_wdata[B_IE:0]),
    .ovf(ovf), .step(step), .ext_fall(ext_fall),
    .run(run_q), .src(src_q), .mode(mode_q), .flag(flag_q), .ie(ie_q),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      unique case (reg_addr)
        A_COUNT: reg_rdata <= cnt_q;
        A_CTRL: begin
          reg_rdata[B_RUN]       <= run_q;
          reg_rdata[B_SRC]       <= src_q;
          reg_rdata[B_MHI:B_MLO] <= mode_q;
        end
        A_FLAG: begin
          reg_rdata[B_FLAG] <= flag_q;
          reg_rdata[B_IE]   <= ie_q;
        end
        default: reg_rdata <= pre_q;
      endcase
    end
  end
endmodule

// File: rtl/tec8_chk.sv
module tec8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             run_q,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] pre_q,
  input logic             flag_q,
  input logic             ovf,
  input logic             wake_o
);
  a_r8_stopped_load: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && !run_q) |=> (cnt_q == $past(reg_wdata)));

  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt_q == $past(pre_q)));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);

  a_r11_flag_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> wake_o);

  a_r6_off_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && mode_q == 2'b00) |=> (cnt_q == $past(cnt_q)));

  a_r5_self_stop: assert property (@(posedge clk) disable iff (rst)
    ($fell(run_q) && !$past(reg_wr && reg_addr == 2'd1)) |-> ($past(mode_q) == 2'b11));
endmodule

bind tec8_unit tec8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run_q(run_q), .mode_q(mode_q), .cnt_q(cnt_q),
  .pre_q(pre_q), .flag_q(flag_q), .ovf(ovf), .wake_o(wake_o)
);

// File: tb/tb_tec8_unit.sv
module tb_tec8_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_clk_i = 1'b0;
  logic       ext_i = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_o, wake_o;

  int errors = 0;
  int checks = 0;
  int wake_n = 0;

  always #2 clk = ~clk;

  tec8_unit dut (
    .clk(clk), .rst(rst), .slow_clk_i(slow_clk_i), .ext_i(ext_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  always @(negedge clk) if (!rst && wake_o) wake_n++;

  // {preload, extra cycles, expected count, expected overflows}
  localparam logic [31:0] VEC [5] = '{
    32'h10_09_1A_00, 32'hFA_09_FE_01, 32'hFE_04_FF_02,
    32'h00_00_01_00, 32'hFF_02_FF_03
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_ext(input int hi, input int lo);
    @(negedge clk); ext_i = 1'b1;
    repeat (hi) @(negedge clk);
    ext_i = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int w0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 irq", irq_o, 0);
    check("R1 wake", wake_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reg", v, 0);
    end

    // Vector walk: timer mode, system clock (R2, R7, R9, R11)
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd0, VEC[i][31:24]);
      w0 = wake_n;
      wr(2'd1, 8'h09);
      repeat (VEC[i][23:16]) @(posedge clk);
      wr(2'd1, 8'h08);
      rd(2'd0, v);
      check("R2 timer count", v, VEC[i][15:8]);
      rd(2'd2, v);
      check("R9 flag after run", v[0], (VEC[i][7:0] != 0));
      @(negedge clk);
      check("R11 wake count", wake_n - w0, VEC[i][7:0]);
    end

    // R12: live counter, read latency
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h09);
    rd(2'd0, v);
    rd(2'd0, v2);
    check("R12 live read step", v2 - v, 2);
    wr(2'd1, 8'h00);

    // R6: mode 00 holds
    wr(2'd0, 8'h33);
    wr(2'd1, 8'h01);
    repeat (20) @(posedge clk);
    rd(2'd0, v);
    check("R6 off mode hold", v, 8'h33);
    wr(2'd1, 8'h00);

    // R3: slow clock source
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h0B);
    rd(2'd1, v);
    check("R2 ctrl readback", v, 8'h0B);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); slow_clk_i = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk_i = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(posedge clk);
    wr(2'd1, 8'h00);
    rd(2'd0, v);
    check("R3 slow tick count", v, 8'h25);

    // R4: event mode
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h05);
    for (int k = 0; k < 7; k++) pulse_ext(3, 3);
    repeat (6) @(posedge clk);
    wr(2'd1, 8'h00);
    rd(2'd0, v);
    check("R4 event count", v, 8'h87);

    // R5: pulse-width mode
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0D);
    repeat (4) @(posedge clk);
    pulse_ext(12, 8);
    rd(2'd1, v);
    check("R5 run self-cleared", v, 8'h0C);
    rd(2'd0, v);
    check("R5 width", v, 12);
    pulse_ext(5, 8);
    rd(2'd0, v);
    check("R5 later pulse ignored", v, 12);

    // R8, R7, R9, R11: preload while running, reload, gating
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h40);
    rd(2'd0, v);
    check("R8 running write no load", v, 8'hFF);
    rd(2'd3, v);
    check("R8 preload readback", v, 8'h40);
    w0 = wake_n;
    pulse_ext(3, 6);
    rd(2'd0, v);
    check("R7 reload value", v, 8'h40);
    rd(2'd2, v);
    check("R9 flag set", v, 8'h01);
    check("R9 irq masked", irq_o, 0);
    check("R11 wake with irq off", wake_n - w0, 1);
    wr(2'd1, 8'h04);
    rd(2'd2, v);
    check("R9 ctrl write keeps flag", v, 8'h01);
    wr(2'd2, 8'h03);
    check("R9 irq enabled", irq_o, 1);
    wr(2'd2, 8'h02);
    check("R9 irq after clear", irq_o, 0);
    rd(2'd2, v);
    check("R9 flag cleared", v, 8'h02);

    // R10: overflow and clear on the same edge
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h09);
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd2, v);
    check("R10 set beats clear", v, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule